// File: doc/BRIEF.md
# DMA Write-Combining Line Buffer

This block sits between the write port of a DMA engine and a system bus master. It owns two line buffers of 32 bytes each. Every buffer records which of its bytes hold data and the line-aligned address those bytes belong to. With combining switched on, byte-enabled word writes that fall in one line collect in a single open buffer. The buffer is drained when one of four events closes it. Draining cuts the valid bytes into the largest naturally aligned pieces and sends them to the bus one after another.

With combining switched off, the block acts as a two-deep posted-write queue. Each accepted write takes a free buffer, which goes straight to draining and stays busy until its last bus write is acknowledged. When both buffers are busy, the DMA is held off by keeping its acknowledge low. A pending-read input stops the block from starting a bus write. It never withdraws a request that is already raised.

Top module: `dma_wcomb`

## Requirements
- R1: After reset both buffers are free and `bus_req` is low.
- R2: With `combine_en` high, a write whose line address (`wr_addr[31:5]`) equals the open buffer's line and whose enabled bytes are all still empty in that buffer is merged into it and causes no bus traffic. At most one buffer is open at a time. `wr_addr[1:0]` must be zero. Enabled byte k of `wr_data[8k+7:8k]` lands at line byte `4*wr_addr[4:2]+k`.
- R3: A write to a different line closes the open buffer and starts draining it.
- R4: A high `flush_req` closes the open buffer and starts draining it.
- R5: A write that enables a byte already valid in the open buffer closes that buffer before the write is stored.
- R6: Lowering `combine_en` closes the open buffer.
- R7: A draining buffer issues writes of 32, 16, 8, 4, 2 or 1 bytes. `bus_size` carries the log2 of the size (0 = 1 byte, 5 = 32 bytes). Each write is naturally aligned, lies wholly inside valid bytes, and is the largest such piece starting at the lowest remaining valid byte. `bus_addr` is the byte address of its first byte. `bus_data` carries the whole line, with line byte j in bits 8j+7:8j.
- R8: With `combine_en` low, each write goes into a free buffer that drains at once. Buffers drain in the order they were closed, and a buffer is freed on the acknowledge of its last piece.
- R9: With `combine_en` low and both buffers busy, `wr_ack` stays low until a buffer is freed.
- R10: While `rd_pending` is high no new bus request starts. A raised `bus_req` holds its address and size until `bus_ack`.
- R11: A write that closes the open buffer is stored in the other buffer as a new line if that buffer is free. Otherwise it waits with `wr_ack` low.
- R12: A write with all byte enables low is acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | DMA write request |
| wr_addr | input | 32 | Byte address of the write word |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| wr_ack | output | 1 | Write accepted this cycle |
| combine_en | input | 1 | Combining mode enable |
| flush_req | input | 1 | Close the open buffer |
| rd_pending | input | 1 | A bus read is waiting; holds off new bus writes |
| bus_req | output | 1 | Bus write request |
| bus_ack | input | 1 | Bus write done |
| bus_addr | output | 32 | Byte address of the bus write |
| bus_size | output | 3 | log2 of transfer bytes |
| bus_data | output | 256 | Line data, byte j at bits 8j+7:8j |

## Verification
The in-module assertions check on every cycle that a bus request holds steady until acknowledged, that a new request never starts over a pending read, and that every transfer is aligned to its own size. They also check that no more than one buffer is open, that a flush turns an open buffer into a draining one, and that a write is held off when both buffers are busy with combining off. Only the bench scenarios show the sequence of transfer sizes for a given byte pattern, the data bytes each transfer carries, the order in which lines leave, and that merging produces no traffic before a close event. The bench also shows that a closing write waits while both buffers are occupied.

// File: rtl/dma_wcomb.sv
module dma_wcomb #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_req,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [31:0]               wr_data,
  input  logic [3:0]                wr_be,
  output logic                      wr_ack,
  input  logic                      combine_en,
  input  logic                      flush_req,
  input  logic                      rd_pending,
  output logic                      bus_req,
  input  logic                      bus_ack,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [$clog2($clog2(LINE_BYTES)+1)-1:0] bus_size,
  output logic [LINE_BYTES*8-1:0]   bus_data
);
  localparam int LG     = $clog2(LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WL     = LG - 2;
  localparam int SZ_W   = $clog2(LG + 1);
  localparam int TAG_W  = ADDR_W - LG;

  typedef enum logic [1:0] {B_FREE, B_OPEN, B_DRAIN} bst_t;

  bst_t                  st  [2];
  logic [LINE_BYTES-1:0] vld [2];
  logic [TAG_W-1:0]      tag [2];
  logic [LINE_W-1:0]     dat [2];
  logic                  dq, inflight;

  logic [TAG_W-1:0]      wline;
  logic [WL-1:0]         wword;
  logic [LINE_BYTES-1:0] wmask;
  logic [LINE_W-1:0]     wdline, wbits;
  logic has_open, o, wr_live, hit, closing, merge, any_free, f, alloc;
  logic any_drain, sv, done, last;
  logic [LINE_BYTES-1:0] vs, xmask;
  logic [LG-1:0]         first;
  logic [SZ_W-1:0]       szc;

  assign wline    = wr_addr[ADDR_W-1:LG];
  assign wword    = wr_addr[LG-1:2];
  assign wmask    = LINE_BYTES'(wr_be) << {wword, 2'b00};
  assign wdline   = LINE_W'(wr_data) << {wword, 5'b00000};
  assign has_open = (st[0] == B_OPEN) || (st[1] == B_OPEN);
  assign o        = (st[1] == B_OPEN);
  assign wr_live  = wr_req && (wr_be != 4'b0);
  assign hit      = (wline == tag[o]) && ((vld[o] & wmask) == '0);
  assign closing  = has_open && (flush_req || !combine_en || (wr_live && !hit));
  assign merge    = has_open && !closing && wr_live;
  assign any_free = (st[0] == B_FREE) || (st[1] == B_FREE);
  assign f        = (st[0] != B_FREE);
  assign alloc    = wr_live && !merge && any_free;
  assign wr_ack   = wr_req && ((wr_be == 4'b0) || merge || any_free);

  always_comb
    for (int j = 0; j < LINE_BYTES; j++) wbits[j*8 +: 8] = {8{wmask[j]}};

  assign any_drain = (st[0] == B_DRAIN) || (st[1] == B_DRAIN);
  assign sv        = (st[dq] == B_DRAIN) ? dq : ~dq;
  assign vs        = vld[sv];

  always_comb begin
    int fi, sz;
    logic found, ok;
    fi = 0; found = 1'b0;
    for (int i = 0; i < LINE_BYTES; i++)
      if (!found && vs[i]) begin fi = i; found = 1'b1; end
    sz = 0;
    for (int k = 0; k <= LG; k++) begin
      ok = ((fi % (1 << k)) == 0);
      for (int j = 0; j < LINE_BYTES; j++)
        if (j >= fi && j < fi + (1 << k) && !vs[j]) ok = 1'b0;
      if (fi + (1 << k) > LINE_BYTES) ok = 1'b0;
      if (ok) sz = k;
    end
    for (int j = 0; j < LINE_BYTES; j++)
      xmask[j] = (j >= fi) && (j < fi + (1 << sz));
    first = LG'(fi);
    szc   = SZ_W'(sz);
  end

  assign bus_req  = any_drain && (inflight || !rd_pending);
  assign bus_addr = {tag[sv], first};
  assign bus_size = szc;
  assign bus_data = dat[sv];
  assign done     = bus_req && bus_ack;
  assign last     = done && ((vs & ~xmask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        st[b] <= B_FREE; vld[b] <= '0; tag[b] <= '0; dat[b] <= '0;
      end
      dq <= 1'b0;
      inflight <= 1'b0;
    end else begin
      inflight <= bus_req && !bus_ack;
      if (done) begin
        vld[sv] <= vs & ~xmask;
        if (last) st[sv] <= B_FREE;
      end
      if (closing) st[o] <= B_DRAIN;
      if (merge) begin
        vld[o] <= vld[o] | wmask;
        dat[o] <= (dat[o] & ~wbits) | (wdline & wbits);
      end
      if (alloc) begin
        st[f]  <= combine_en ? B_OPEN : B_DRAIN;
        tag[f] <= wline;
        vld[f] <= wmask;
        dat[f] <= wdline & wbits;
      end
      if (last) dq <= ~sv;
      else if (!any_drain) begin
        if (closing) dq <= o;
        else if (alloc && !combine_en) dq <= f;
      end
    end
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size));
  a_r10_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !rd_pending);
  a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[LG-1:0] & LG'((1 << bus_size) - 1)) == '0);
  a_r2_one_open: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st[0] == B_OPEN, st[1] == B_OPEN}));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_addr[1:0] == 2'b00);
  a_r4_flush_closes: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && st[0] == B_OPEN |=> st[0] == B_DRAIN);
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !combine_en && wr_live && st[0] != B_FREE && st[1] != B_FREE |-> !wr_ack);
endmodule

// File: tb/tb_dma_wcomb.sv
module tb_dma_wcomb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 1'b0, combine_en = 1'b0, flush_req = 1'b0, rd_pending = 1'b0, bus_ack = 1'b0;
  logic [31:0] wr_addr = '0, wr_data = '0;
  logic [3:0] wr_be = '0;
  logic wr_ack, bus_req;
  logic [31:0] bus_addr;
  logic [2:0] bus_size;
  logic [255:0] bus_data;

  dma_wcomb dut (.clk, .rst_n, .wr_req, .wr_addr, .wr_data, .wr_be, .wr_ack,
    .combine_en, .flush_req, .rd_pending, .bus_req, .bus_ack, .bus_addr, .bus_size, .bus_data);

  always #5 clk = ~clk;

  int checks = 0, errs = 0, nlog = 0, cyc = 0;
  bit resp_en = 1'b1, summarized = 1'b0;
  logic [15:0] log_addr [0:63];
  logic [2:0]  log_size [0:63];

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "R1 watchdog", cyc, 150000);
      summary();
    end
  end

  // bus responder: one acknowledge per request, data bytes checked against fb()
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (resp_en && bus_req) begin
      bit ok;
      ok = 1'b1;
      log_addr[nlog] = bus_addr[15:0];
      log_size[nlog] = bus_size;
      if (nlog < 63) nlog++;
      for (int b = 0; b < (1 << bus_size); b++)
        if (bus_data[(int'(bus_addr[4:0]) + b) * 8 +: 8] != fb(bus_addr + b)) ok = 1'b0;
      chk(ok, "R7 data lanes", bus_addr, bus_addr);
      bus_ack = 1'b1;
    end
  end

  task automatic do_write(input logic [31:0] a, input logic [3:0] be);
    @(negedge clk);
    wr_addr = a; wr_be = be; wr_req = 1'b1;
    wr_data = {fb(a + 3), fb(a + 2), fb(a + 1), fb(a)};
    #1;
    while (!wr_ack) begin @(negedge clk); #1; end
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
  endtask

  // {combine_en, action(0 none,1 flush after,2 drop combine after), addr[15:0], be}
  localparam int NW = 21;
  localparam logic [22:0] WV [0:NW-1] = '{
    {1'b1, 2'd0, 16'h0100, 4'hF}, {1'b1, 2'd0, 16'h0104, 4'hF},   // R2 merge
    {1'b1, 2'd0, 16'h0108, 4'hF}, {1'b1, 2'd1, 16'h010C, 4'hF},   // R4 flush
    {1'b1, 2'd0, 16'h0140, 4'hE}, {1'b1, 2'd1, 16'h0144, 4'hF},   // R7 split
    {1'b1, 2'd0, 16'h0180, 4'hF}, {1'b1, 2'd1, 16'h01A0, 4'hF},   // R3 new line
    {1'b1, 2'd0, 16'h01C0, 4'h3}, {1'b1, 2'd1, 16'h01C0, 4'h6},   // R5 overlap
    {1'b1, 2'd0, 16'h0200, 4'hF}, {1'b1, 2'd0, 16'h0204, 4'hF},
    {1'b1, 2'd0, 16'h0208, 4'hF}, {1'b1, 2'd0, 16'h020C, 4'hF},
    {1'b1, 2'd0, 16'h0210, 4'hF}, {1'b1, 2'd0, 16'h0214, 4'hF},
    {1'b1, 2'd0, 16'h0218, 4'hF}, {1'b1, 2'd1, 16'h021C, 4'hF},   // R7 full line
    {1'b0, 2'd0, 16'h0240, 4'hF}, {1'b0, 2'd0, 16'h0244, 4'hC},   // R8 posted
    {1'b1, 2'd2, 16'h0280, 4'hF}                                  // R6 combine drop
  };
  // expected transfers {addr, log2 size}
  localparam int NE = 13;
  localparam logic [18:0] EV [0:NE-1] = '{
    {16'h0100, 3'd4},
    {16'h0141, 3'd0}, {16'h0142, 3'd1}, {16'h0144, 3'd2},
    {16'h0180, 3'd2}, {16'h01A0, 3'd2},
    {16'h01C0, 3'd1}, {16'h01C1, 3'd0}, {16'h01C2, 3'd0},
    {16'h0200, 3'd5},
    {16'h0240, 3'd2}, {16'h0246, 3'd1},
    {16'h0280, 3'd2}
  };

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R1 reset bus_req", bus_req, 0);
    chk(wr_ack == 1'b0, "R1 reset wr_ack", wr_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b0, "R1 idle after reset", bus_req, 0);

    for (int i = 0; i < NW; i++) begin
      combine_en = WV[i][22];
      do_write({16'h0, WV[i][19:4]}, WV[i][3:0]);
      if (i == 3) begin
        chk(bus_req == 1'b0, "R2 no traffic while merging", bus_req, 0);
        chk(nlog == 0, "R2 no transfers before flush", nlog, 0);
      end
      if (WV[i][21:20] == 2'd1) do_flush();
      if (WV[i][21:20] == 2'd2) begin @(negedge clk); combine_en = 1'b0; end
    end
    for (int t = 0; t < 400 && nlog < NE; t++) @(negedge clk);
    chk(nlog == NE, "R7 transfer count", nlog, NE);
    for (int i = 0; i < NE; i++)
      chk({log_addr[i], log_size[i]} == EV[i], "R7 transfer addr/size",
          {log_addr[i], log_size[i]}, EV[i]);

    // R12: empty byte enables
    repeat (10) @(negedge clk);
    n0 = nlog;
    do_write(32'h300, 4'h0);
    repeat (10) @(negedge clk);
    chk(nlog == n0, "R12 empty write no traffic", nlog, n0);

    // R10 gate, R9 stall, R8 ordering
    rd_pending = 1'b1;
    combine_en = 1'b0;
    do_write(32'h300, 4'hF);
    do_write(32'h304, 4'hF);
    repeat (5) @(negedge clk);
    chk(bus_req == 1'b0, "R10 read pending blocks", bus_req, 0);
    wr_addr = 32'h308; wr_be = 4'hF; wr_req = 1'b1;
    wr_data = {fb(32'h30B), fb(32'h30A), fb(32'h309), fb(32'h308)};
    repeat (4) @(negedge clk);
    #1 chk(wr_ack == 1'b0, "R9 both busy stalls", wr_ack, 0);
    @(negedge clk);
    rd_pending = 1'b0;
    #1;
    while (!wr_ack) begin @(negedge clk); #1; end
    @(negedge clk); wr_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(nlog == n0 + 3, "R8 posted count", nlog, n0 + 3);
    chk(log_addr[n0] == 16'h300 && log_size[n0] == 3'd2, "R8 first post", log_addr[n0], 16'h300);
    chk(log_addr[n0+1] == 16'h304, "R8 second post", log_addr[n0+1], 16'h304);
    chk(log_addr[n0+2] == 16'h308, "R8 third post", log_addr[n0+2], 16'h308);

    // R11: closing write waits while no buffer is free
    n0 = nlog;
    resp_en = 1'b0;
    combine_en = 1'b1;
    do_write(32'h400, 4'hF);
    do_write(32'h420, 4'hF);
    @(negedge clk);
    chk(bus_req == 1'b1, "R3 new line starts drain", bus_req, 1);
    wr_addr = 32'h440; wr_be = 4'hF; wr_req = 1'b1;
    wr_data = {fb(32'h443), fb(32'h442), fb(32'h441), fb(32'h440)};
    repeat (4) @(negedge clk);
    #1 chk(wr_ack == 1'b0, "R11 closing write stalls", wr_ack, 0);
    @(negedge clk);
    resp_en = 1'b1;
    #1;
    while (!wr_ack) begin @(negedge clk); #1; end
    @(negedge clk); wr_req = 1'b0;
    do_flush();
    repeat (20) @(negedge clk);
    chk(nlog == n0 + 3, "R11 transfer count", nlog, n0 + 3);
    chk(log_addr[n0] == 16'h400, "R11 order first", log_addr[n0], 16'h400);
    chk(log_addr[n0+1] == 16'h420, "R11 order second", log_addr[n0+1], 16'h420);
    chk(log_addr[n0+2] == 16'h440, "R11 order third", log_addr[n0+2], 16'h440);
    summary();
  end
endmodule